// File: doc/BRIEF.md
# Iterative Two-Mode CORDIC Engine

This block turns angles into sine and cosine values and (x, y) pairs into angles by shift-and-add micro-rotations. It serves the angle-based packing and unpacking of unitary weight matrices. In that flow, phases become rotation factors and complex entries become phases. A single `mode` input picks the job. In rotate mode the engine starts from a pre-scaled unit vector and turns it through the requested angle, so `x_out` and `y_out` end as cosine and sine. In vector mode it turns the supplied pair onto the positive x axis and accumulates the angle it needed, so `z_out` ends as the pair's argument over the whole circle.

The engine runs one micro-rotation per clock over a fixed schedule of ten steps. It does not hold the elementary angles itself. On every step it puts the step number on `ang_addr` and takes that step's angle from `ang_data` in the same cycle, so the constants live in an external table that can be loaded as needed. All values are 16-bit two's complement. Vector components use 14 fraction bits, so 1.0 is 16384. Angles use a binary scale on which half a turn (pi) is 2^15, so they wrap modulo a full turn.

Top module: `cordic_engine`

## Requirements
- R1: After reset `done` is 0, `x_out`, `y_out` and `z_out` are 0, and `ang_addr` is 0.
- R2: A start in rotate mode (`mode` = 0) loads x = 9949 (0.607253 in the 14-fraction-bit scale), y = 0 and z = `z_in`. `x_in` and `y_in` have no effect on the result.
- R3: Each step i computes x' = x − d·(y >>> i), y' = y + d·(x >>> i) and z' = z − d·A(i). Here >>> is an arithmetic right shift, A(i) is the `ang_data` word read at address i, and the arithmetic is 16-bit wrapping. In rotate mode d = +1 when z ≥ 0 and d = −1 otherwise.
- R4: A start in vector mode (`mode` = 1) loads x = `x_in`, y = `y_in` and z = 0 when `x_in` ≥ 0. When `x_in` < 0 it loads x = −`x_in`, y = −`y_in` and z = 0x8000 (pi). During steps, d = −1 when y ≥ 0 and d = +1 otherwise.
- R5: Exactly ten steps run. If a start is taken at clock edge n, `ang_addr` equals i after edge n+i for i = 0..9, and `done` is 1 for exactly the one cycle following edge n+10.
- R6: `start` is ignored while an operation is in progress; the running result is unaffected.
- R7: Between operations `x_out`, `y_out` and `z_out` hold the last result until the next accepted start.
- R8: When the table holds round(atan(2^-i)·2^15/pi), rotate mode with |`z_in`| ≤ 2^14 gives cosine and sine within 64 LSB. Vector mode with |`x_in`|, |`y_in`| ≤ 2^13 and a nonzero pair gives the angle within 48 LSB, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 1 | 0 rotate, 1 vector |
| x_in | input | 16 | Initial x (vector mode) |
| y_in | input | 16 | Initial y (vector mode) |
| z_in | input | 16 | Angle to rotate by (rotate mode) |
| ang_addr | output | 4 | Step index used as table address |
| ang_data | input | 16 | Elementary angle for the addressed step |
| x_out | output | 16 | x register |
| y_out | output | 16 | y register |
| z_out | output | 16 | z register |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The hardest paths to reach are the vector-mode inputs in the left half-plane. There the pi pre-rotation has to combine with the 16-bit wrap of the angle. The point (−8000, 0) must land on −32768, which is the same as +pi. The stimulus drives pairs in both left quadrants and on the negative axis, and compares the angle with a wrapping distance. A second stimulus raises `start` again with different operands part-way through a run, and checks that the result still belongs to the first operands.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
    typedef enum logic {
        MODE_ROT = 1'b0,
        MODE_VEC = 1'b1
    } cordic_mode_e;
endpackage

// File: rtl/cordic_seq.sv
// Step sequencer: accepts a start when idle, walks the step index, pulses done.
module cordic_seq #(
    parameter  int ITERS = 10,
    localparam int AW    = (ITERS > 1) ? $clog2(ITERS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] idx
);
    localparam logic [AW-1:0] LAST = AW'(ITERS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [AW-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.idx  = '0;
            end
        end else if (seq_q.idx == LAST) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
            seq_d.idx  = '0;
        end else begin
            seq_d.idx = seq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign load = start && !seq_q.busy;
    assign busy = seq_q.busy;
    assign done = seq_q.done;
    assign idx  = seq_q.idx;

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= LAST)); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && $past(idx) == LAST)); // R5
    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R6
endmodule

// File: rtl/cordic_microrot.sv
// One shift-and-add micro-rotation; the direction comes from y or z sign.
module cordic_microrot #(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  logic signed [W-1:0] z_i,
    input  logic [AW-1:0]       step,
    input  logic [W-1:0]        ang,
    input  logic                steer_by_y,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o,
    output logic signed [W-1:0] z_o
);
    logic signed [W-1:0] x_sh, y_sh, a_s;
    logic                d_pos;

    always_comb begin
        x_sh  = x_i >>> step;
        y_sh  = y_i >>> step;
        a_s   = $signed(ang);
        // vector: rotate up when y is negative; rotate: follow the sign of z
        d_pos = steer_by_y ? y_i[W-1] : ~z_i[W-1];
        if (d_pos) begin
            x_o = x_i - y_sh;
            y_o = y_i + x_sh;
            z_o = z_i - a_s;
        end else begin
            x_o = x_i + y_sh;
            y_o = y_i - x_sh;
            z_o = z_i + a_s;
        end
    end
endmodule

// File: rtl/cordic_engine.sv
module cordic_engine #(
    parameter  int W     = 16,
    parameter  int ITERS = 10,
    parameter  int GAIN  = 9949,
    localparam int AW    = (ITERS > 1) ? $clog2(ITERS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic [W-1:0]  x_in,
    input  logic [W-1:0]  y_in,
    input  logic [W-1:0]  z_in,
    output logic [AW-1:0] ang_addr,
    input  logic [W-1:0]  ang_data,
    output logic [W-1:0]  x_out,
    output logic [W-1:0]  y_out,
    output logic [W-1:0]  z_out,
    output logic          done
);
    import cordic_pkg::*;

    localparam logic signed [W-1:0] HALF_TURN = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] K_INIT    = W'(GAIN);

    typedef struct packed {
        logic signed [W-1:0] x;
        logic signed [W-1:0] y;
        logic signed [W-1:0] z;
        logic                vec;
    } dp_t;

    dp_t                 dp_d, dp_q;
    logic                load, busy;
    logic [AW-1:0]       step;
    logic signed [W-1:0] x_nx, y_nx, z_nx;
    logic signed [W-1:0] xin_s, yin_s;

    assign xin_s = $signed(x_in);
    assign yin_s = $signed(y_in);

    cordic_seq #(.ITERS(ITERS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .busy  (busy),
        .done  (done),
        .idx   (step)
    );

    cordic_microrot #(.W(W), .AW(AW)) u_rot (
        .x_i        (dp_q.x),
        .y_i        (dp_q.y),
        .z_i        (dp_q.z),
        .step       (step),
        .ang        (ang_data),
        .steer_by_y (dp_q.vec),
        .x_o        (x_nx),
        .y_o        (y_nx),
        .z_o        (z_nx)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.vec = (cordic_mode_e'(mode) == MODE_VEC);
            if (cordic_mode_e'(mode) == MODE_ROT) begin
                dp_d.x = K_INIT;
                dp_d.y = '0;
                dp_d.z = $signed(z_in);
            end else if (xin_s[W-1]) begin
                // left half-plane: turn by pi first so the steps converge
                dp_d.x = -xin_s;
                dp_d.y = -yin_s;
                dp_d.z = HALF_TURN;
            end else begin
                dp_d.x = xin_s;
                dp_d.y = yin_s;
                dp_d.z = '0;
            end
        end else if (busy) begin
            dp_d.x = x_nx;
            dp_d.y = y_nx;
            dp_d.z = z_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign ang_addr = step;
    assign x_out    = dp_q.x;
    assign y_out    = dp_q.y;
    assign z_out    = dp_q.z;

    AST_ROT_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mode) |=> (x_out == K_INIT && y_out == '0)); // R2
    AST_VEC_X_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dp_q.vec) |-> !dp_q.x[W-1]); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out))); // R7
    AST_STEP_ZERO_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && ang_addr == '0)); // R5
endmodule

// File: tb/sim_cordic_engine.sv
module sim_cordic_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] x_in = '0, y_in = '0, z_in = '0;
    logic [3:0]  ang_addr;
    logic [15:0] ang_data;
    logic [15:0] x_out, y_out, z_out;
    logic        done;

    int nchk = 0;
    int nerr = 0;

    logic [15:0] tbl [10];

    typedef struct {
        logic signed [15:0] ex, ey, ez;
        int  ix, iy, iz;
        bit  tol_rot, tol_vec;
        string tag;
    } item_t;
    item_t sbq[$];
    logic [15:0] last_x, last_y, last_z;

    always #2 clk = ~clk;

    assign ang_data = (ang_addr < 4'd10) ? tbl[ang_addr] : 16'h0000;

    cordic_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .ang_addr(ang_addr), .ang_data(ang_data),
        .x_out(x_out), .y_out(y_out), .z_out(z_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R5", "unexpected done", 1, 0);
            end else begin
                item_t it;
                logic signed [15:0] dz;
                it = sbq.pop_front();
                chk(x_out == it.ex, it.tag, "x exact", $signed(x_out), it.ex);
                chk(y_out == it.ey, it.tag, "y exact", $signed(y_out), it.ey);
                chk(z_out == it.ez, it.tag, "z exact", $signed(z_out), it.ez);
                if (it.tol_rot) begin
                    chk(absi($signed(x_out) - it.ix) <= 64, "R8", "cosine", $signed(x_out), it.ix);
                    chk(absi($signed(y_out) - it.iy) <= 64, "R8", "sine", $signed(y_out), it.iy);
                end
                if (it.tol_vec) begin
                    dz = z_out - 16'(it.iz);
                    chk(absi(dz) <= 48, "R8", "angle", $signed(z_out), it.iz);
                end
                last_x = x_out; last_y = y_out; last_z = z_out;
            end
        end
    end

    // Driver: builds expected result from R2/R3/R4 and runs one operation
    task automatic run_op(input bit vec, input int xi, input int yi, input int zi,
                          input bit glitch, input bit tol, input string tag);
        item_t it;
        logic signed [15:0] mx, my, mz, sx, sy;
        int cnt;
        bit seen;
        if (!vec) begin
            mx = 16'sd9949; my = 0; mz = 16'(zi);
        end else if (xi < 0) begin
            mx = 16'(-xi); my = 16'(-yi); mz = 16'h8000;
        end else begin
            mx = 16'(xi); my = 16'(yi); mz = 0;
        end
        for (int i = 0; i < 10; i++) begin
            bit dp;
            sx = mx >>> i; sy = my >>> i;
            dp = vec ? my[15] : !mz[15];
            if (dp) begin mx = mx - sy; my = my + sx; mz = mz - $signed(tbl[i]); end
            else    begin mx = mx + sy; my = my - sx; mz = mz + $signed(tbl[i]); end
        end
        it.ex = mx; it.ey = my; it.ez = mz; it.tag = tag;
        it.tol_rot = tol && !vec;
        it.tol_vec = tol && vec;
        if (!vec) begin
            real a;
            a = real'(zi) * 3.141592653589793 / 32768.0;
            it.ix = rnd($cos(a) * 16384.0);
            it.iy = rnd($sin(a) * 16384.0);
            it.iz = 0;
        end else begin
            it.ix = 0; it.iy = 0;
            it.iz = rnd($atan2(real'(yi), real'(xi)) * 32768.0 / 3.141592653589793);
        end
        sbq.push_back(it);

        @(negedge clk);
        mode = vec; x_in = 16'(xi); y_in = 16'(yi); z_in = 16'(zi); start = 1'b1;
        cnt = 0; seen = 0;
        while (!seen && cnt < 30) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) start = 1'b0;
            if (glitch && cnt == 4) begin
                mode = ~vec; x_in = 16'h1234; y_in = 16'hE000; z_in = 16'h2000; start = 1'b1;
            end
            if (glitch && cnt == 5) start = 1'b0;
            if (done) begin
                seen = 1;
                chk(cnt == 11, "R5", "done cycle", cnt, 11);
            end else if (cnt <= 10) begin
                chk(ang_addr == 4'(cnt - 1), "R5", "step address", ang_addr, cnt - 1);
            end
        end
        if (!seen) chk(1'b0, "R5", "done never rose", cnt, 11);
        @(negedge clk);
        chk(done == 1'b0, "R5", "done pulse width", done, 0);
    endtask

    initial begin
        #(4 * 200000);
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < 10; i++)
            tbl[i] = 16'(rnd($atan(2.0 ** (-i)) * 32768.0 / 3.141592653589793));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 0, "R1", "done", done, 0);
        chk(x_out == 0 && y_out == 0 && z_out == 0, "R1", "outputs", x_out | y_out | z_out, 0);
        chk(ang_addr == 0, "R1", "address", ang_addr, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 rotate-mode recurrences over several angles
        run_op(0, 0, 0, 0, 0, 1, "R3");
        run_op(0, 0, 0, 8192, 0, 1, "R3");
        run_op(0, 0, 0, -8192, 0, 1, "R3");
        run_op(0, 0, 0, 16384, 0, 1, "R3");
        run_op(0, 0, 0, -16384, 0, 1, "R3");
        run_op(0, 0, 0, 1000, 0, 1, "R3");
        // R2: x_in/y_in present but must not matter
        run_op(0, 12345, -7777, -12345, 0, 1, "R2");
        // R4 vector mode, right and left half-planes and the axes
        run_op(1, 8000, 0, 0, 0, 1, "R4");
        run_op(1, 5000, 5000, 0, 0, 1, "R4");
        run_op(1, 0, 8000, 0, 0, 1, "R4");
        run_op(1, 0, -8000, 0, 0, 1, "R4");
        run_op(1, 3000, -7000, 0, 0, 1, "R4");
        run_op(1, -6000, 3000, 0, 0, 1, "R4");
        run_op(1, -6000, -3000, 0, 0, 1, "R4");
        run_op(1, -8000, 0, 0, 0, 1, "R4");
        // R6: a second start mid-run with other operands
        run_op(0, 0, 0, 5000, 1, 1, "R6");
        run_op(1, -4000, 7000, 0, 1, 1, "R6");
        // R7: outputs hold while idle
        repeat (6) @(negedge clk);
        chk(x_out == last_x, "R7", "x held", x_out, last_x);
        chk(y_out == last_y, "R7", "y held", y_out, last_y);
        chk(z_out == last_z, "R7", "z held", z_out, last_z);
        chk(sbq.size() == 0, "R5", "pending results", sbq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule